// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host port of a display driver and turns a stream of bytes into configuration. Each byte comes with a flag that says whether it is a command opcode or an argument. The decoder recognises a small set of opcodes and gathers the argument bytes each one needs. It then updates a bank of registers that the rest of the driver reads: sleep state, the two drive phase lengths, the clock divide code, the oscillator trim, two GPIO modes, the second precharge length, and a grayscale pulse-width table.

Most opcodes take zero or one argument. The table-load opcode is the exception. It takes one byte per grayscale level, and those bytes go into a shadow buffer. The active table changes only when a terminating zero command arrives after the last byte. Any other byte discards the load. A separate opcode restores a linear table and raises a one-cycle pulse. How the host bus times its transfers is outside this block.

Top module: `dcmd_decoder`

## Requirements
- R1: While reset is held and after it is released, `sleep_on` is 1, both GPIO modes are 00, `phase1_len`, `phase2_len`, `clk_div_code`, `osc_trim` and `precharge2_len` are 0, `lin_pulse` is 0, and the table holds the linear values (level k = k*LIN_STEP, with LIN_STEP = 8).
- R2: Command 0xAE sets `sleep_on` to 1 and command 0xAF clears it. Neither takes an argument, and the new value is visible in the cycle after the byte is accepted.
- R3: Command 0xB1 followed by one argument byte sets `phase1_len` to arg[3:0] and `phase2_len` to arg[7:4].
- R4: Command 0xB3 followed by one argument byte sets `clk_div_code` to arg[3:0] and `osc_trim` to arg[7:4].
- R5: Command 0xB5 followed by one argument byte sets `gpio0_mode` to arg[1:0] and `gpio1_mode` to arg[3:2], and arg[7:4] has no effect. The mode codes are 00 input off, 01 input on, 10 drive low, 11 drive high.
- R6: Command 0xB6 followed by one argument byte sets `precharge2_len` to arg[3:0].
- R7: Command 0xB8, then GS_LEVELS argument bytes, then command 0x00 loads the table. The n-th argument byte (n = 1..15) becomes level n, which is `gs_table[(n-1)*8 +: 8]`.
- R8: A table load is discarded, and the active table is unchanged, if anything other than command 0x00 follows the last table byte, or if a command interrupts the load early. A command that interrupts a load is still decoded as a command.
- R9: Command 0xB9 reloads the linear table and drives `lin_pulse` high for exactly the one cycle after the byte.
- R10: Unknown opcodes, and argument bytes that arrive with no command waiting for them, change no output.
- R11: A command that arrives while an argument is still pending cancels the pending opcode and is decoded itself. A later argument byte is then ignored.
- R12: A byte presented with `in_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_cmd | input | 1 | 1 = opcode byte, 0 = argument byte |
| in_byte | input | 8 | Byte value |
| sleep_on | output | 1 | Sleep mode active (display off) |
| phase1_len | output | 4 | Drive phase 1 length code |
| phase2_len | output | 4 | Drive phase 2 length code |
| clk_div_code | output | 4 | Display clock divide code |
| osc_trim | output | 4 | Oscillator frequency trim |
| gpio0_mode | output | 2 | GPIO0 mode |
| gpio1_mode | output | 2 | GPIO1 mode |
| precharge2_len | output | 4 | Second precharge length |
| gs_table | output | 120 | Active table, level n in bits [(n-1)*8 +: 8] |
| lin_pulse | output | 1 | One-cycle pulse on a linear-table request |

## Verification
The bench builds the block with its default parameters: fifteen table levels of eight bits and a linear step of 8. With these values the bench can run the full-length table sequence and check the exact count at which the terminator becomes valid. It also covers loads cut off in the middle, loads cut off right after the last byte, and restoring the linear table after a custom load. Single-argument opcodes are checked both when completed and when a command interrupts them.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_END       = 8'h00;
  localparam logic [BYTE_W-1:0] OP_SLEEP_ON  = 8'hAE;
  localparam logic [BYTE_W-1:0] OP_SLEEP_OFF = 8'hAF;
  localparam logic [BYTE_W-1:0] OP_PHASE     = 8'hB1;
  localparam logic [BYTE_W-1:0] OP_CLOCK     = 8'hB3;
  localparam logic [BYTE_W-1:0] OP_GPIO      = 8'hB5;
  localparam logic [BYTE_W-1:0] OP_PRE2      = 8'hB6;
  localparam logic [BYTE_W-1:0] OP_TABLE     = 8'hB8;
  localparam logic [BYTE_W-1:0] OP_LINEAR    = 8'hB9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARG  = 2'd1,
    ST_GS   = 2'd2,
    ST_TERM = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic sleep_wr;
    logic sleep_val;
    logic phase_wr;
    logic clock_wr;
    logic gpio_wr;
    logic pre2_wr;
  } cfg_wr_t;
endpackage

// File: rtl/dcmd_seq.sv
module dcmd_seq
  import dcmd_pkg::*;
#(
  parameter int GS_LEVELS = 15,
  localparam int IDX_W = (GS_LEVELS > 1) ? $clog2(GS_LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_cmd,
  input  logic [BYTE_W-1:0] in_byte,
  output cfg_wr_t           cfg_wr,
  output logic              sh_wr,
  output logic [IDX_W-1:0]  sh_idx,
  output logic              tbl_commit,
  output logic              tbl_linear
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GS_LEVELS - 1);

  seq_state_t        state_q, state_d;
  logic [BYTE_W-1:0] op_q, op_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    cnt_d      = cnt_q;
    cfg_wr     = '0;
    sh_wr      = 1'b0;
    tbl_commit = 1'b0;
    tbl_linear = 1'b0;
    if (in_valid) begin
      if (in_cmd) begin
        state_d = ST_IDLE;
        if (state_q == ST_TERM && in_byte == OP_END) begin
          tbl_commit = 1'b1;
        end else begin
          unique case (in_byte)
            OP_SLEEP_ON: begin
              cfg_wr.sleep_wr  = 1'b1;
              cfg_wr.sleep_val = 1'b1;
            end
            OP_SLEEP_OFF: begin
              cfg_wr.sleep_wr  = 1'b1;
              cfg_wr.sleep_val = 1'b0;
            end
            OP_LINEAR: tbl_linear = 1'b1;
            OP_PHASE, OP_CLOCK, OP_GPIO, OP_PRE2: begin
              state_d = ST_ARG;
              op_d    = in_byte;
            end
            OP_TABLE: begin
              state_d = ST_GS;
              cnt_d   = '0;
            end
            default: ;
          endcase
        end
      end else begin
        state_d = ST_IDLE;
        unique case (state_q)
          ST_ARG: begin
            unique case (op_q)
              OP_PHASE: cfg_wr.phase_wr = 1'b1;
              OP_CLOCK: cfg_wr.clock_wr = 1'b1;
              OP_GPIO:  cfg_wr.gpio_wr  = 1'b1;
              OP_PRE2:  cfg_wr.pre2_wr  = 1'b1;
              default: ;
            endcase
          end
          ST_GS: begin
            sh_wr = 1'b1;
            if (cnt_q == LAST_IDX) begin
              state_d = ST_TERM;
            end else begin
              state_d = ST_GS;
              cnt_d   = cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sh_idx = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/dcmd_cfg_regs.sv
module dcmd_cfg_regs
  import dcmd_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_wr_t           cfg_wr,
  input  logic [BYTE_W-1:0] arg,
  output logic              sleep_on,
  output logic [LEN_W-1:0]  phase1_len,
  output logic [LEN_W-1:0]  phase2_len,
  output logic [LEN_W-1:0]  clk_div_code,
  output logic [LEN_W-1:0]  osc_trim,
  output logic [MODE_W-1:0] gpio0_mode,
  output logic [MODE_W-1:0] gpio1_mode,
  output logic [LEN_W-1:0]  precharge2_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_on <= 1'b1;
    else if (cfg_wr.sleep_wr) sleep_on <= cfg_wr.sleep_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase1_len <= '0;
      phase2_len <= '0;
    end else if (cfg_wr.phase_wr) begin
      phase1_len <= arg[LEN_W-1:0];
      phase2_len <= arg[2*LEN_W-1:LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_div_code <= '0;
      osc_trim     <= '0;
    end else if (cfg_wr.clock_wr) begin
      clk_div_code <= arg[LEN_W-1:0];
      osc_trim     <= arg[2*LEN_W-1:LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio0_mode <= '0;
      gpio1_mode <= '0;
    end else if (cfg_wr.gpio_wr) begin
      gpio0_mode <= arg[MODE_W-1:0];
      gpio1_mode <= arg[2*MODE_W-1:MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) precharge2_len <= '0;
    else if (cfg_wr.pre2_wr) precharge2_len <= arg[LEN_W-1:0];
  end
endmodule

// File: rtl/dcmd_gray_table.sv
module dcmd_gray_table
  import dcmd_pkg::*;
#(
  parameter int GS_LEVELS = 15,
  parameter int LIN_STEP  = 8,
  localparam int IDX_W   = (GS_LEVELS > 1) ? $clog2(GS_LEVELS) : 1,
  localparam int TABLE_W = GS_LEVELS * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sh_wr,
  input  logic [IDX_W-1:0]   sh_idx,
  input  logic [BYTE_W-1:0]  sh_byte,
  input  logic               tbl_commit,
  input  logic               tbl_linear,
  output logic [TABLE_W-1:0] gs_table,
  output logic               lin_pulse
);
  for (genvar g = 0; g < GS_LEVELS; g++) begin : g_level
    localparam logic [BYTE_W-1:0] LIN_VAL = BYTE_W'((g + 1) * LIN_STEP);
    logic [BYTE_W-1:0] shadow_q;
    logic [BYTE_W-1:0] active_q;
    logic              sh_en;

    assign sh_en = sh_wr && (sh_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q <= '0;
      else if (sh_en) shadow_q <= sh_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= LIN_VAL;
      else if (tbl_linear) active_q <= LIN_VAL;
      else if (tbl_commit) active_q <= shadow_q;
    end

    assign gs_table[g*BYTE_W +: BYTE_W] = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lin_pulse <= 1'b0;
    else lin_pulse <= tbl_linear;
  end
endmodule

// File: rtl/dcmd_decoder.sv
module dcmd_decoder
  import dcmd_pkg::*;
#(
  parameter int GS_LEVELS = 15,
  parameter int LIN_STEP  = 8,
  parameter int LEN_W     = 4,
  parameter int MODE_W    = 2,
  localparam int IDX_W   = (GS_LEVELS > 1) ? $clog2(GS_LEVELS) : 1,
  localparam int TABLE_W = GS_LEVELS * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_cmd,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic               sleep_on,
  output logic [LEN_W-1:0]   phase1_len,
  output logic [LEN_W-1:0]   phase2_len,
  output logic [LEN_W-1:0]   clk_div_code,
  output logic [LEN_W-1:0]   osc_trim,
  output logic [MODE_W-1:0]  gpio0_mode,
  output logic [MODE_W-1:0]  gpio1_mode,
  output logic [LEN_W-1:0]   precharge2_len,
  output logic [TABLE_W-1:0] gs_table,
  output logic               lin_pulse
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  cfg_wr_t          cfg_wr;
  logic             sh_wr;
  logic [IDX_W-1:0] sh_idx;
  logic             tbl_commit;
  logic             tbl_linear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dcmd_seq #(.GS_LEVELS(GS_LEVELS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_cmd     (in_cmd),
    .in_byte    (in_byte),
    .cfg_wr     (cfg_wr),
    .sh_wr      (sh_wr),
    .sh_idx     (sh_idx),
    .tbl_commit (tbl_commit),
    .tbl_linear (tbl_linear)
  );

  dcmd_cfg_regs #(.LEN_W(LEN_W), .MODE_W(MODE_W)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .cfg_wr         (cfg_wr),
    .arg            (in_byte),
    .sleep_on       (sleep_on),
    .phase1_len     (phase1_len),
    .phase2_len     (phase2_len),
    .clk_div_code   (clk_div_code),
    .osc_trim       (osc_trim),
    .gpio0_mode     (gpio0_mode),
    .gpio1_mode     (gpio1_mode),
    .precharge2_len (precharge2_len)
  );

  dcmd_gray_table #(.GS_LEVELS(GS_LEVELS), .LIN_STEP(LIN_STEP)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sh_wr      (sh_wr),
    .sh_idx     (sh_idx),
    .sh_byte    (in_byte),
    .tbl_commit (tbl_commit),
    .tbl_linear (tbl_linear),
    .gs_table   (gs_table),
    .lin_pulse  (lin_pulse)
  );
endmodule

// File: rtl/dcmd_decoder_chk.sv
module dcmd_decoder_chk
  import dcmd_pkg::*;
#(
  parameter int TABLE_W = 120,
  parameter int MODE_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_cmd,
  input logic [BYTE_W-1:0]  in_byte,
  input logic               sleep_on,
  input logic [MODE_W-1:0]  gpio0_mode,
  input logic [MODE_W-1:0]  gpio1_mode,
  input logic [TABLE_W-1:0] gs_table,
  input logic               lin_pulse
);
  p_sleep_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sleep_on) |->
      $past(in_valid && in_cmd && (in_byte == OP_SLEEP_ON || in_byte == OP_SLEEP_OFF)));

  p_gpio_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gpio0_mode) || !$stable(gpio1_mode)) |-> $past(in_valid && !in_cmd));

  p_table_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gs_table) |->
      $past(in_valid && in_cmd && (in_byte == OP_END || in_byte == OP_LINEAR)));

  p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lin_pulse |-> $past(in_valid && in_cmd && in_byte == OP_LINEAR));

  p_pulse_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cmd && in_byte == OP_LINEAR) |=> lin_pulse);

  p_sleep_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cmd && in_byte == OP_SLEEP_ON) |=> sleep_on);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(sleep_on) && $stable(gs_table) && !lin_pulse));
endmodule

bind dcmd_decoder dcmd_decoder_chk #(.TABLE_W(TABLE_W), .MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .in_valid   (in_valid),
  .in_cmd     (in_cmd),
  .in_byte    (in_byte),
  .sleep_on   (sleep_on),
  .gpio0_mode (gpio0_mode),
  .gpio1_mode (gpio1_mode),
  .gs_table   (gs_table),
  .lin_pulse  (lin_pulse)
);

// File: tb/dcmd_decoder_test.sv
module dcmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 15;
  localparam int STEP = 8;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_cmd;
  logic [7:0]   in_byte;
  logic         sleep_on;
  logic [3:0]   phase1_len, phase2_len, clk_div_code, osc_trim, precharge2_len;
  logic [1:0]   gpio0_mode, gpio1_mode;
  logic [119:0] gs_table;
  logic         lin_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_byte(in_byte),
    .sleep_on(sleep_on), .phase1_len(phase1_len), .phase2_len(phase2_len),
    .clk_div_code(clk_div_code), .osc_trim(osc_trim), .gpio0_mode(gpio0_mode),
    .gpio1_mode(gpio1_mode), .precharge2_len(precharge2_len), .gs_table(gs_table),
    .lin_pulse(lin_pulse)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit c, logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_cmd = c; in_byte = d;
    @(negedge clk);
    in_valid = 0; in_cmd = 0; in_byte = 8'h5A;
  endtask

  function automatic logic [7:0] custom(int k);
    return 8'(k * 11 + 3);
  endfunction

  task automatic check_table(string req, bit linear);
    for (int k = 1; k <= LEVELS; k++)
      check(req, gs_table[(k-1)*8 +: 8], linear ? (k*STEP) : int'(custom(k)));
  endtask

  task automatic t_reset_r1;
    check("R1 sleep", sleep_on, 1);
    check("R1 gpio0", gpio0_mode, 0);
    check("R1 gpio1", gpio1_mode, 0);
    check("R1 phase", {phase2_len, phase1_len}, 0);
    check("R1 clock", {osc_trim, clk_div_code}, 0);
    check("R1 pre2", precharge2_len, 0);
    check("R1 pulse", lin_pulse, 0);
    check_table("R1 table", 1);
  endtask

  task automatic t_sleep_r2;
    send(1, 8'hAF); check("R2 off", sleep_on, 0);
    send(1, 8'hAE); check("R2 on", sleep_on, 1);
    send(1, 8'hAF); check("R2 off again", sleep_on, 0);
  endtask

  task automatic t_phase_r3;
    send(1, 8'hB1); send(0, 8'hC7);
    check("R3 phase1", phase1_len, 7);
    check("R3 phase2", phase2_len, 12);
  endtask

  task automatic t_clock_r4;
    send(1, 8'hB3); send(0, 8'hF2);
    check("R4 div", clk_div_code, 2);
    check("R4 osc", osc_trim, 15);
  endtask

  task automatic t_gpio_r5;
    send(1, 8'hB5); send(0, 8'hAE);
    check("R5 gpio0", gpio0_mode, 2);
    check("R5 gpio1", gpio1_mode, 3);
    send(1, 8'hB5); send(0, 8'h51);
    check("R5 gpio0 b", gpio0_mode, 1);
    check("R5 gpio1 b", gpio1_mode, 0);
  endtask

  task automatic t_pre2_r6;
    send(1, 8'hB6); send(0, 8'h9D);
    check("R6 pre2", precharge2_len, 13);
  endtask

  task automatic t_ignore_r10;
    send(1, 8'hA0);
    send(0, 8'h33);
    send(1, 8'h00);
    check("R10 phase", {phase2_len, phase1_len}, 8'hC7);
    check("R10 clock", {osc_trim, clk_div_code}, 8'hF2);
    check("R10 gpio", {gpio1_mode, gpio0_mode}, 4'b0001);
    check("R10 pre2", precharge2_len, 13);
    check("R10 sleep", sleep_on, 0);
    check("R10 pulse", lin_pulse, 0);
    check_table("R10 table", 1);
  endtask

  task automatic t_interrupt_r11;
    send(1, 8'hB1);
    send(1, 8'hAE);
    check("R11 new cmd decoded", sleep_on, 1);
    send(0, 8'h44);
    check("R11 pending dropped", {phase2_len, phase1_len}, 8'hC7);
    send(1, 8'hB6);
    send(1, 8'hAF);
    send(0, 8'h02);
    check("R11 pre2 kept", precharge2_len, 13);
    check("R11 sleep", sleep_on, 0);
  endtask

  task automatic t_invalid_r12;
    @(negedge clk);
    in_valid = 0; in_cmd = 1; in_byte = 8'hAE;
    @(negedge clk);
    @(negedge clk);
    in_cmd = 0; in_byte = 8'h5A;
    check("R12 sleep", sleep_on, 0);
  endtask

  task automatic load_table(int nbytes);
    send(1, 8'hB8);
    for (int k = 1; k <= nbytes; k++) send(0, custom(k));
  endtask

  task automatic t_table_r7;
    load_table(LEVELS);
    check_table("R7 not before end", 1);
    send(1, 8'h00);
    check_table("R7 loaded", 0);
  endtask

  task automatic t_abort_r8;
    send(1, 8'hB9);
    load_table(LEVELS);
    send(1, 8'hAE);
    check_table("R8 other cmd", 1);
    check("R8 cmd decoded", sleep_on, 1);
    send(1, 8'h00);
    check_table("R8 late end", 1);
    load_table(LEVELS);
    send(0, 8'h00);
    send(1, 8'h00);
    check_table("R8 data after", 1);
    load_table(5);
    send(1, 8'h00);
    check_table("R8 short", 1);
    load_table(LEVELS);
    send(1, 8'h00);
    check_table("R8 reload ok", 0);
  endtask

  task automatic t_linear_r9;
    send(1, 8'hB9);
    check("R9 pulse high", lin_pulse, 1);
    check_table("R9 linear", 1);
    @(negedge clk);
    check("R9 pulse one cycle", lin_pulse, 0);
  endtask

  initial begin
    in_valid = 0; in_cmd = 0; in_byte = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset sleep", sleep_on, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_sleep_r2();
    t_phase_r3();
    t_clock_r4();
    t_gpio_r5();
    t_pre2_r6();
    t_ignore_r10();
    t_interrupt_r11();
    t_invalid_r12();
    t_table_r7();
    t_abort_r8();
    t_linear_r9();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule